// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block turns the addressing fields of an interrupt message into the set of local processor units that should receive it. The system has up to `NUM_UNITS` units. The resolver holds a small table with one entry per unit: the unit's physical ID, its logical destination byte and its 4-bit destination model. Software or an init sequencer fills the table through a single write port.

Each request carries four things: an 8-bit destination, a destination-mode bit that selects physical or logical addressing, a 2-bit shorthand code and the index of the sending unit. From these the resolver produces a target bitmask with one bit per unit. It also reduces that mask to a single chosen target, which is used when the message asks for lowest-priority delivery.

The matching logic is combinational. Every result passes through one output register, so a request presented before a clock edge appears on the outputs after that edge. A table write is also registered, so it affects only requests presented from the following cycle on.

Top module: `irq_dest_resolver`

## Requirements
- R1: `res_valid` equals `req_valid` one cycle later. After a cycle with `req_valid` low, `res_mask`, `lp_hit`, `lp_onehot` and `lp_idx` are all zero.
- R2: Shorthand code 1 targets only the unit whose index is `sender_idx`. The destination fields are ignored.
- R3: Shorthand code 2 targets every populated unit. The destination fields are ignored.
- R4: Shorthand code 3 targets every populated unit except the sender.
- R5: With shorthand 0 and `dest_logical` = 0, destination 0xFF targets every populated unit.
- R6: With shorthand 0 and `dest_logical` = 0, any other destination targets only the lowest-indexed populated unit whose physical ID equals it. If no unit matches, the mask is zero.
- R7: With shorthand 0 and `dest_logical` = 1, a unit with model 0xF (flat) is targeted when `dest` AND its logical byte is nonzero.
- R8: With shorthand 0 and `dest_logical` = 1, a unit with model 0x0 (cluster) is targeted when bits [7:4] of `dest` equal bits [7:4] of its logical byte and bits [3:0] of the two share at least one set bit.
- R9: A unit whose model is neither 0x0 nor 0xF is never targeted in logical mode.
- R10: Unit i counts as populated only if entries 0 through i have all been written since reset. An unpopulated unit never appears in `res_mask`, whatever the shorthand or mode.
- R11: `lp_onehot` holds only the lowest set bit of `res_mask` and `lp_idx` is that bit's index. `lp_hit` is high exactly when `res_mask` is nonzero. With no target, `lp_onehot` and `lp_idx` are zero.
- R12: Synchronous reset clears every populated flag and drives all outputs to zero.
- R13: A table write affects requests presented from the next cycle on. A request in the same cycle as the write resolves against the old table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| dest | input | 8 | Destination field |
| dest_logical | input | 1 | 0 = physical addressing, 1 = logical addressing |
| shorthand | input | 2 | 0 = use destination fields, 1 = sender only, 2 = all units, 3 = all units except sender |
| sender_idx | input | IDX_W | Index of the sending unit |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | IDX_W | Table entry to write |
| wr_phys_id | input | 8 | Physical ID of the written entry |
| wr_log_dest | input | 8 | Logical destination byte of the written entry |
| wr_model | input | 4 | Destination model nibble of the written entry |
| res_valid | output | 1 | Registered result valid |
| res_mask | output | NUM_UNITS | Target bitmask |
| lp_hit | output | 1 | At least one target exists |
| lp_onehot | output | NUM_UNITS | Lowest-indexed target, one-hot |
| lp_idx | output | IDX_W | Index of the lowest-indexed target |

## Verification
The directed patterns target one distinction each:
- Every shorthand code is sent with a destination that would match something else, so ignoring the fields can be told apart from using them.
- Two units share a physical ID, which shows that the lowest index wins.
- Logical destinations are chosen so that flat, cluster and unknown-model units answer differently to the same byte.
- A gap left in the table shows that units above the gap are excluded until it is filled.
- A request issued in the same cycle as a table write shows that it resolves against the old contents.

A random phase then mixes writes, modes and shorthands. A behavioural model checks the full output set on every clock.

// File: rtl/irqdst_pkg.sv
package irqdst_pkg;
  localparam int DEST_W  = 8;
  localparam int MODEL_W = 4;

  localparam logic [MODEL_W-1:0] MODEL_FLAT    = 4'hF;
  localparam logic [MODEL_W-1:0] MODEL_CLUSTER = 4'h0;
  localparam logic [DEST_W-1:0]  DEST_BCAST    = 8'hFF;

  typedef enum logic [1:0] {
    SH_FIELDS = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  typedef struct packed {
    logic [DEST_W-1:0]  phys_id;
    logic [DEST_W-1:0]  log_dest;
    logic [MODEL_W-1:0] model;
  } unit_entry_t;
endpackage

// File: rtl/irqdst_table.sv
module irqdst_table #(
  parameter int NUM_UNITS = 8,
  parameter int IDX_W     = $clog2(NUM_UNITS)
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 wr_en,
  input  logic [IDX_W-1:0]                     wr_idx,
  input  irqdst_pkg::unit_entry_t              wr_entry,
  output irqdst_pkg::unit_entry_t [NUM_UNITS-1:0] ent_o,
  output logic [NUM_UNITS-1:0]                 elig_o
);
  irqdst_pkg::unit_entry_t mem [NUM_UNITS];
  logic [NUM_UNITS-1:0]    written;

  // Entry storage: no reset, so it can map onto distributed RAM.
  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_idx) < NUM_UNITS)) mem[wr_idx] <= wr_entry;
  end

  // One written flag per entry; reset clears them.
  always_ff @(posedge clk) begin
    if (rst) written <= '0;
    else if (wr_en && (int'(wr_idx) < NUM_UNITS)) written[wr_idx] <= 1'b1;
  end

  always_comb begin
    for (int i = 0; i < NUM_UNITS; i++) ent_o[i] = mem[i];
  end

  // A unit is eligible only when it and every entry below it are written.
  assign elig_o[0] = written[0];
  for (genvar g = 1; g < NUM_UNITS; g++) begin : g_prefix
    assign elig_o[g] = elig_o[g-1] & written[g];
  end
endmodule

// File: rtl/irqdst_match.sv
module irqdst_match #(
  parameter int NUM_UNITS = 8,
  parameter int IDX_W     = $clog2(NUM_UNITS)
) (
  input  irqdst_pkg::unit_entry_t [NUM_UNITS-1:0] ent_i,
  input  logic [NUM_UNITS-1:0]                 elig_i,
  input  logic [irqdst_pkg::DEST_W-1:0]        dest_i,
  input  logic                                 logical_i,
  input  logic [1:0]                           shorthand_i,
  input  logic [IDX_W-1:0]                     sender_i,
  output logic [NUM_UNITS-1:0]                 mask_o
);
  import irqdst_pkg::*;

  localparam logic [NUM_UNITS-1:0] ONE = {{(NUM_UNITS-1){1'b0}}, 1'b1};

  logic [NUM_UNITS-1:0] phys_hit, log_hit, phys_cand, phys_first, self_bit, raw;

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
    logic flat_hit, clus_hit;
    assign phys_hit[g] = (ent_i[g].phys_id == dest_i);
    assign flat_hit = (ent_i[g].model == MODEL_FLAT) &&
                      ((dest_i & ent_i[g].log_dest) != '0);
    assign clus_hit = (ent_i[g].model == MODEL_CLUSTER) &&
                      (dest_i[7:4] == ent_i[g].log_dest[7:4]) &&
                      ((dest_i[3:0] & ent_i[g].log_dest[3:0]) != '0);
    assign log_hit[g] = flat_hit | clus_hit;
  end

  // Physical match: lowest eligible unit carrying the ID.
  assign phys_cand  = phys_hit & elig_i;
  assign phys_first = phys_cand & (~phys_cand + ONE);
  assign self_bit   = ONE << sender_i;

  always_comb begin
    unique case (shorthand_e'(shorthand_i))
      SH_SELF:   raw = self_bit;
      SH_ALL:    raw = '1;
      SH_OTHERS: raw = ~self_bit;
      default: begin
        if (logical_i)                raw = log_hit;
        else if (dest_i == DEST_BCAST) raw = '1;
        else                          raw = phys_first;
      end
    endcase
    mask_o = raw & elig_i;
  end
endmodule

// File: rtl/irqdst_lowpick.sv
module irqdst_lowpick #(
  parameter int NUM_UNITS = 8,
  parameter int IDX_W     = $clog2(NUM_UNITS)
) (
  input  logic [NUM_UNITS-1:0] req_i,
  output logic [NUM_UNITS-1:0] onehot_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic                 any_o
);
  always_comb begin
    onehot_o = '0;
    idx_o    = '0;
    for (int i = NUM_UNITS - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        onehot_o = '0;
        onehot_o[i] = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
    any_o = |req_i;
  end
endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver #(
  parameter int NUM_UNITS = 8,
  parameter int IDX_W     = $clog2(NUM_UNITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [7:0]           dest,
  input  logic                 dest_logical,
  input  logic [1:0]           shorthand,
  input  logic [IDX_W-1:0]     sender_idx,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [7:0]           wr_phys_id,
  input  logic [7:0]           wr_log_dest,
  input  logic [3:0]           wr_model,
  output logic                 res_valid,
  output logic [NUM_UNITS-1:0] res_mask,
  output logic                 lp_hit,
  output logic [NUM_UNITS-1:0] lp_onehot,
  output logic [IDX_W-1:0]     lp_idx
);
  import irqdst_pkg::*;

  unit_entry_t [NUM_UNITS-1:0] ent;
  unit_entry_t                 wr_entry;
  logic [NUM_UNITS-1:0]        elig, mask_c, pick_c;
  logic [IDX_W-1:0]            pick_idx_c;
  logic                        pick_any_c;

  assign wr_entry = '{phys_id: wr_phys_id, log_dest: wr_log_dest, model: wr_model};

  irqdst_table #(.NUM_UNITS(NUM_UNITS), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_entry(wr_entry), .ent_o(ent), .elig_o(elig)
  );

  irqdst_match #(.NUM_UNITS(NUM_UNITS), .IDX_W(IDX_W)) u_match (
    .ent_i(ent), .elig_i(elig), .dest_i(dest), .logical_i(dest_logical),
    .shorthand_i(shorthand), .sender_i(sender_idx), .mask_o(mask_c)
  );

  irqdst_lowpick #(.NUM_UNITS(NUM_UNITS), .IDX_W(IDX_W)) u_pick (
    .req_i(mask_c), .onehot_o(pick_c), .idx_o(pick_idx_c), .any_o(pick_any_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_mask  <= '0;
      lp_hit    <= 1'b0;
      lp_onehot <= '0;
      lp_idx    <= '0;
    end else begin
      res_valid <= req_valid;
      res_mask  <= req_valid ? mask_c : '0;
      lp_hit    <= req_valid & pick_any_c;
      lp_onehot <= req_valid ? pick_c : '0;
      lp_idx    <= req_valid ? pick_idx_c : '0;
    end
  end
endmodule

// File: rtl/irq_dest_resolver_chk.sv
module irq_dest_resolver_chk #(
  parameter int NUM_UNITS = 8,
  parameter int IDX_W     = $clog2(NUM_UNITS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic [1:0]           shorthand,
  input logic [IDX_W-1:0]     sender_idx,
  input logic                 res_valid,
  input logic [NUM_UNITS-1:0] res_mask,
  input logic                 lp_hit,
  input logic [NUM_UNITS-1:0] lp_onehot,
  input logic [IDX_W-1:0]     lp_idx
);
  localparam logic [NUM_UNITS-1:0] ONE = {{(NUM_UNITS-1){1'b0}}, 1'b1};

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);
  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!res_valid && res_mask == '0 && !lp_hit && lp_onehot == '0));
  assert_self_only_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && shorthand == 2'd1) |=> ((res_mask & ~(ONE << $past(sender_idx))) == '0));
  assert_others_skip_sender_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && shorthand == 2'd3) |=> !res_mask[$past(sender_idx)]);
  assert_pick_onehot_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lp_onehot));
  assert_pick_inside_R11: assert property (@(posedge clk) disable iff (rst)
    (lp_onehot & ~res_mask) == '0);
  assert_pick_lowest_R11: assert property (@(posedge clk) disable iff (rst)
    (res_mask & (lp_onehot - ONE) & ~lp_onehot) == '0 || !lp_hit);
  assert_hit_matches_mask_R11: assert property (@(posedge clk) disable iff (rst)
    lp_hit == (res_mask != '0));
  assert_idx_agrees_R11: assert property (@(posedge clk) disable iff (rst)
    lp_hit |-> lp_onehot[lp_idx]);
  assert_reset_clears_R12: assert property (@(posedge clk)
    rst |=> (!res_valid && res_mask == '0 && !lp_hit));
endmodule

bind irq_dest_resolver irq_dest_resolver_chk #(.NUM_UNITS(NUM_UNITS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .shorthand(shorthand),
  .sender_idx(sender_idx), .res_valid(res_valid), .res_mask(res_mask),
  .lp_hit(lp_hit), .lp_onehot(lp_onehot), .lp_idx(lp_idx)
);

// File: tb/tb_irq_dest_resolver.sv
module tb_irq_dest_resolver;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [7:0] dest = '0;
  logic dest_logical = 1'b0;
  logic [1:0] shorthand = '0;
  logic [IW-1:0] sender_idx = '0;
  logic wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [7:0] wr_phys_id = '0, wr_log_dest = '0;
  logic [3:0] wr_model = '0;
  logic res_valid, lp_hit;
  logic [N-1:0] res_mask, lp_onehot;
  logic [IW-1:0] lp_idx;

  always #2.5 clk = ~clk;

  irq_dest_resolver #(.NUM_UNITS(N)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .dest(dest),
    .dest_logical(dest_logical), .shorthand(shorthand), .sender_idx(sender_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_phys_id(wr_phys_id),
    .wr_log_dest(wr_log_dest), .wr_model(wr_model),
    .res_valid(res_valid), .res_mask(res_mask), .lp_hit(lp_hit),
    .lp_onehot(lp_onehot), .lp_idx(lp_idx)
  );

  // Reference table
  int m_id[N], m_log[N], m_model[N];
  bit m_wr[N];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  function automatic int ref_mask(int d, bit lg, int sh, int snd);
    int r = 0;
    bit ok = 1'b1;
    bit found = 1'b0;
    for (int i = 0; i < N; i++) begin
      bit sel = 1'b0;
      ok = ok && m_wr[i];
      if (!ok) break;
      case (sh)
        1: sel = (i == snd);
        2: sel = 1'b1;
        3: sel = (i != snd);
        default: begin
          if (lg) begin
            if (m_model[i] == 15) sel = ((d & m_log[i]) != 0);
            else if (m_model[i] == 0)
              sel = ((d >> 4) == (m_log[i] >> 4)) && (((d & 15) & (m_log[i] & 15)) != 0);
          end else if (d == 255) sel = 1'b1;
          else if (!found && m_id[i] == d) begin sel = 1'b1; found = 1'b1; end
        end
      endcase
      if (sel) r |= (1 << i);
    end
    return r;
  endfunction

  task automatic step(string tag);
    int e_valid, e_mask, e_hit, e_one, e_idx;
    @(posedge clk);
    e_valid = 0; e_mask = 0;
    if (rst) begin
      for (int i = 0; i < N; i++) m_wr[i] = 1'b0;
    end else begin
      e_valid = req_valid;
      if (req_valid) e_mask = ref_mask(dest, dest_logical, shorthand, sender_idx);
      if (wr_en) begin
        m_id[wr_idx] = wr_phys_id; m_log[wr_idx] = wr_log_dest;
        m_model[wr_idx] = wr_model; m_wr[wr_idx] = 1'b1;
      end
    end
    e_hit = (e_mask != 0); e_one = 0; e_idx = 0;
    for (int i = N - 1; i >= 0; i--) if (e_mask[i]) begin e_one = 1 << i; e_idx = i; end
    @(negedge clk);
    checks++;
    if (res_valid !== e_valid[0] || res_mask !== e_mask[N-1:0] || lp_hit !== e_hit[0] ||
        lp_onehot !== e_one[N-1:0] || lp_idx !== e_idx[IW-1:0]) begin
      fails++;
      $display("FAIL %s: got v=%0b mask=%02h hit=%0b one=%02h idx=%0d exp v=%0d mask=%02h hit=%0d one=%02h idx=%0d",
               tag, res_valid, res_mask, lp_hit, lp_onehot, lp_idx,
               e_valid, e_mask, e_hit, e_one, e_idx);
    end
  endtask

  task automatic req(int sh, bit lg, int d, int snd, string tag);
    req_valid = 1'b1; shorthand = 2'(sh); dest_logical = lg;
    dest = 8'(d); sender_idx = IW'(snd);
    step(tag);
    req_valid = 1'b0;
  endtask

  task automatic wr(int idx, int id, int lgd, int mdl);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_phys_id = 8'(id);
    wr_log_dest = 8'(lgd); wr_model = 4'(mdl);
  endtask

  initial begin
    // R12: outputs held at zero during reset, even with a request present
    req_valid = 1'b1; shorthand = 2'd2;
    step("R12 reset");
    step("R12 reset");
    req_valid = 1'b0;
    rst = 1'b0;
    step("R1 idle");
    req(2, 0, 0, 0, "R10 empty table broadcast");
    // R13: request in the same cycle as the first write sees the old table
    wr(0, 8'h10, 8'h01, 15);
    req(2, 0, 0, 0, "R13 write same cycle");
    wr_en = 1'b0;
    req(2, 0, 0, 0, "R13 write next cycle");
    wr(1, 8'h11, 8'h02, 15);  step("R1 write");
    wr(2, 8'h20, 8'h31, 0);   step("R1 write");
    wr(3, 8'h11, 8'h34, 0);   step("R1 write");
    wr(4, 8'h05, 8'h0F, 5);   step("R1 write");
    wr(6, 8'h06, 8'hFF, 15);  step("R1 write");
    wr_en = 1'b0;
    req(1, 0, 8'hFF, 2, "R2 self");
    req(1, 0, 0, 6, "R2 R10 self unpopulated");
    req(2, 1, 8'h00, 0, "R3 all");
    req(3, 0, 8'h10, 0, "R4 others");
    req(3, 0, 0, 4, "R4 others top");
    req(0, 0, 8'hFF, 0, "R5 physical broadcast");
    req(0, 0, 8'h11, 0, "R6 duplicate id lowest");
    req(0, 0, 8'h20, 0, "R6 unique id");
    req(0, 0, 8'h77, 0, "R6 no match");
    req(0, 0, 8'h06, 0, "R10 id beyond gap");
    req(0, 1, 8'h03, 0, "R7 flat");
    req(0, 1, 8'h31, 0, "R7 R8 mixed");
    req(0, 1, 8'h3C, 0, "R8 cluster");
    req(0, 1, 8'h2C, 0, "R8 cluster nibble mismatch");
    req(0, 1, 8'h0F, 0, "R9 unknown model");
    step("R1 idle");
    wr(5, 8'h55, 8'h80, 15); step("R10 fill gap");
    wr_en = 1'b0;
    req(0, 0, 8'h06, 0, "R10 gap filled");
    req(2, 0, 0, 0, "R3 all after fill");
    req(0, 1, 8'h80, 0, "R11 pick higher unit");
    // Random mix
    for (int k = 0; k < 300; k++) begin
      wr_en = ($urandom_range(0, 3) == 0);
      wr_idx = IW'($urandom_range(0, N - 1));
      wr_phys_id = 8'($urandom_range(0, 7) + 8'h10);
      wr_log_dest = 8'($urandom);
      wr_model = ($urandom_range(0, 2) == 0) ? 4'h0 : (($urandom_range(0, 3) == 0) ? 4'h3 : 4'hF);
      req_valid = ($urandom_range(0, 4) != 0);
      shorthand = 2'($urandom);
      dest_logical = 1'($urandom);
      dest = ($urandom_range(0, 9) == 0) ? 8'hFF : 8'($urandom_range(0, 7) + 8'h10);
      if (dest_logical) dest = 8'($urandom);
      sender_idx = IW'($urandom);
      step("R11 random mix");
    end
    wr_en = 1'b0; req_valid = 1'b0;
    rst = 1'b1; step("R12 reset again");
    rst = 1'b0;
    req(2, 0, 0, 0, "R12 table cleared");
    req(0, 0, 8'hFF, 0, "R12 R5 broadcast cleared");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule